// File: doc/BRIEF.md
# Sign-Sign LMS Calibration Engine

This block is the digital half of a self-calibrating image-reject receiver. It adapts three correction coefficients: gain trim, phase trim and comparator offset trim. The adaptation uses a sign-sign least-mean-square rule. On every qualified update strobe, each coefficient moves by exactly one LSB. The direction of that move is the XOR of the error sign from a comparator and the sign of that coefficient's regressor, so no multiplier is needed.

The gain coefficient follows the first regressor and the phase coefficient follows the second. The offset coefficient has a regressor that is always positive, so it tracks the error sign alone. Adaptation takes place only while calibration mode is enabled; outside it, the coefficients hold their values indefinitely.

Each coefficient is also presented as a two-level one-hot code for a segmented resistor-string DAC. The upper bits pick a ladder segment and the lower bits pick one of the subdivisions inside it, which keeps the converter monotonic.

Top module: `sslms_cal_engine`

## Requirements
- R1: After reset, all three coefficient codes read mid-scale, 1024 for the default 11-bit width.
- R2: On a qualified update, the gain code rises by 1 when err_sgn XOR x1_sgn is 0 and falls by 1 when it is 1. Sign encoding: 1 means negative, 0 means positive.
- R3: On a qualified update, the phase code rises by 1 when err_sgn XOR x2_sgn is 0 and falls by 1 when it is 1.
- R4: On a qualified update, the offset code rises by 1 when err_sgn is 0 and falls by 1 when err_sgn is 1, because its regressor is a constant positive value.
- R5: An update is qualified only when upd_stb and cal_en are both 1 at a rising clock edge. Otherwise none of the three codes changes.
- R6: A code at 2047 that is told to rise stays at 2047. A code at 0 that is told to fall stays at 0. Codes never wrap.
- R7: The segment output has exactly one bit set, at index code[10:6+(-1)]... more precisely code[10:5]. The subdivision output has exactly one bit set, at index code[4:0].
- R8: A qualified update at a rising edge is visible on the code and one-hot outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cal_en | input | 1 | Calibration mode enable |
| upd_stb | input | 1 | One-cycle update strobe, once per update period |
| err_sgn | input | 1 | Error sign from the comparator (1 = negative) |
| x1_sgn | input | 1 | Regressor sign for gain (1 = negative) |
| x2_sgn | input | 1 | Regressor sign for phase (1 = negative) |
| gain_code | output | 11 | Gain coefficient |
| phase_code | output | 11 | Phase coefficient |
| ofs_code | output | 11 | Offset coefficient |
| gain_seg | output | 64 | Gain DAC segment one-hot |
| gain_sub | output | 32 | Gain DAC subdivision one-hot |
| phase_seg | output | 64 | Phase DAC segment one-hot |
| phase_sub | output | 32 | Phase DAC subdivision one-hot |
| ofs_seg | output | 64 | Offset DAC segment one-hot |
| ofs_sub | output | 32 | Offset DAC subdivision one-hot |

## Verification
The bench builds the block with its default parameters: an 11-bit code split into a 6-bit segment field and a 5-bit subdivision field. At this width a run of about a thousand same-direction updates drives a coefficient from mid-scale to a rail. The bench uses that to exercise both saturation limits directly, and it crosses every segment boundary on the way, where the subdivision index wraps and the segment index advances. Random signs, random strobes and a random calibration enable then cover the XOR direction rule and the hold behaviour with a mixed pattern of updates.

// File: rtl/sslms_pkg.sv
package sslms_pkg;
  localparam int NUM_COEF = 3;
  typedef enum int {
    IDX_GAIN  = 0,
    IDX_PHASE = 1,
    IDX_OFS   = 2
  } coef_idx_e;
endpackage

// File: rtl/sslms_coef.sv
module sslms_coef #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         dir_dn,
  output logic [W-1:0] coef_o
);
  localparam logic [W-1:0] MID  = W'(1) << (W - 1);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] coef_q, coef_d;

  always_comb begin
    coef_d = coef_q;
    if (upd_en) begin
      if (dir_dn) begin
        if (coef_q != '0) coef_d = coef_q - W'(1);
      end else begin
        if (coef_q != MAXV) coef_d = coef_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= MID;
    else if (upd_en) coef_q <= coef_d;
  end

  assign coef_o = coef_q;

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(coef_q));
  // R6
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !dir_dn && coef_q == MAXV) |=> coef_q == MAXV);
  // R6
  sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && dir_dn && coef_q == '0) |=> coef_q == '0);
  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && coef_q != MAXV && coef_q != '0) |=>
      (coef_q == $past(coef_q) + W'(1) || coef_q == $past(coef_q) - W'(1)));
endmodule

// File: rtl/sslms_seg_dec.sv
module sslms_seg_dec #(
  parameter int W      = 11,
  parameter int FINE_W = 5
) (
  input  logic [W-1:0]               code_i,
  output logic [(1<<(W-FINE_W))-1:0] seg_o,
  output logic [(1<<FINE_W)-1:0]     sub_o
);
  localparam int COARSE_W = W - FINE_W;
  localparam int SEG_N    = 1 << COARSE_W;
  localparam int SUB_N    = 1 << FINE_W;

  logic [COARSE_W-1:0] seg_idx;
  logic [FINE_W-1:0]   sub_idx;

  assign seg_idx = code_i[W-1:FINE_W];
  assign sub_idx = code_i[FINE_W-1:0];

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    assign seg_o[g] = (seg_idx == COARSE_W'(g));
  end
  for (genvar h = 0; h < SUB_N; h++) begin : g_sub
    assign sub_o[h] = (sub_idx == FINE_W'(h));
  end
endmodule

// File: rtl/sslms_cal_engine.sv
module sslms_cal_engine
  import sslms_pkg::*;
#(
  parameter int W      = 11,
  parameter int FINE_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cal_en,
  input  logic                        upd_stb,
  input  logic                        err_sgn,
  input  logic                        x1_sgn,
  input  logic                        x2_sgn,
  output logic [W-1:0]                gain_code,
  output logic [W-1:0]                phase_code,
  output logic [W-1:0]                ofs_code,
  output logic [(1<<(W-FINE_W))-1:0]  gain_seg,
  output logic [(1<<FINE_W)-1:0]      gain_sub,
  output logic [(1<<(W-FINE_W))-1:0]  phase_seg,
  output logic [(1<<FINE_W)-1:0]      phase_sub,
  output logic [(1<<(W-FINE_W))-1:0]  ofs_seg,
  output logic [(1<<FINE_W)-1:0]      ofs_sub
);
  localparam int SEG_N = 1 << (W - FINE_W);
  localparam int SUB_N = 1 << FINE_W;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                upd_en;
  logic [NUM_COEF-1:0] reg_sgn;
  logic [W-1:0]        code_a [NUM_COEF];
  logic [SEG_N-1:0]    seg_a  [NUM_COEF];
  logic [SUB_N-1:0]    sub_a  [NUM_COEF];

  assign upd_en = cal_en & upd_stb;

  always_comb begin
    reg_sgn           = '0;
    reg_sgn[IDX_GAIN]  = x1_sgn;
    reg_sgn[IDX_PHASE] = x2_sgn;
    reg_sgn[IDX_OFS]   = 1'b0;
  end

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
    logic dir_dn;
    assign dir_dn = err_sgn ^ reg_sgn[k];

    sslms_coef #(.W(W)) u_coef (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .upd_en (upd_en),
      .dir_dn (dir_dn),
      .coef_o (code_a[k])
    );

    sslms_seg_dec #(.W(W), .FINE_W(FINE_W)) u_dec (
      .code_i (code_a[k]),
      .seg_o  (seg_a[k]),
      .sub_o  (sub_a[k])
    );
  end

  assign gain_code  = code_a[IDX_GAIN];
  assign phase_code = code_a[IDX_PHASE];
  assign ofs_code   = code_a[IDX_OFS];
  assign gain_seg   = seg_a[IDX_GAIN];
  assign gain_sub   = sub_a[IDX_GAIN];
  assign phase_seg  = seg_a[IDX_PHASE];
  assign phase_sub  = sub_a[IDX_PHASE];
  assign ofs_seg    = seg_a[IDX_OFS];
  assign ofs_sub    = sub_a[IDX_OFS];

  // R7
  gain_seg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones(gain_seg) == 1 && $countones(gain_sub) == 1);
  // R7
  ofs_seg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones(ofs_seg) == 1 && $countones(ofs_sub) == 1);
  // R4
  ofs_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (upd_en && !err_sgn && ofs_code != {W{1'b1}}) |=> ofs_code == $past(ofs_code) + W'(1));
endmodule

// File: tb/sslms_cal_engine_tb.sv
module sslms_cal_engine_tb;
  localparam int W = 11;
  localparam int FINE_W = 5;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n, cal_en, upd_stb, err_sgn, x1_sgn, x2_sgn;
  logic [W-1:0] gain_code, phase_code, ofs_code;
  logic [63:0] gain_seg, phase_seg, ofs_seg;
  logic [31:0] gain_sub, phase_sub, ofs_sub;

  int n_chk = 0;
  int n_bad = 0;
  int exp_g, exp_p, exp_o;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sslms_cal_engine #(.W(W), .FINE_W(FINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .upd_stb(upd_stb),
    .err_sgn(err_sgn), .x1_sgn(x1_sgn), .x2_sgn(x2_sgn),
    .gain_code(gain_code), .phase_code(phase_code), .ofs_code(ofs_code),
    .gain_seg(gain_seg), .gain_sub(gain_sub),
    .phase_seg(phase_seg), .phase_sub(phase_sub),
    .ofs_seg(ofs_seg), .ofs_sub(ofs_sub));

  function automatic int nxt(int v, bit dn);
    if (dn) return (v == 0) ? 0 : v - 1;
    return (v == MAXV) ? MAXV : v + 1;
  endfunction

  function automatic logic [63:0] seg_of(int v);
    return 64'(1) << (v >> FINE_W);
  endfunction

  function automatic logic [31:0] sub_of(int v);
    return 32'(1) << (v & 31);
  endfunction

  task automatic chk(string tag, string what, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic check_all(string tg, string tp, string to);
    chk(tg, "gain_code", gain_code, exp_g);
    chk(tp, "phase_code", phase_code, exp_p);
    chk(to, "ofs_code", ofs_code, exp_o);
    chk("R7", "gain_seg", gain_seg, seg_of(exp_g));
    chk("R7", "gain_sub", gain_sub, sub_of(exp_g));
    chk("R7", "phase_seg", phase_seg, seg_of(exp_p));
    chk("R7", "phase_sub", phase_sub, sub_of(exp_p));
    chk("R7", "ofs_seg", ofs_seg, seg_of(exp_o));
    chk("R7", "ofs_sub", ofs_sub, sub_of(exp_o));
  endtask

  // one clock: model the edge with the applied inputs, then compare (R8)
  task automatic step(string tg, string tp, string to);
    @(posedge clk);
    if (cal_en && upd_stb) begin
      exp_g = nxt(exp_g, err_sgn ^ x1_sgn);
      exp_p = nxt(exp_p, err_sgn ^ x2_sgn);
      exp_o = nxt(exp_o, err_sgn);
    end
    @(negedge clk);
    check_all(tg, tp, to);
  endtask

  initial begin
    rst_n = 1'b0; cal_en = 1'b0; upd_stb = 1'b0;
    err_sgn = 1'b0; x1_sgn = 1'b0; x2_sgn = 1'b0;
    exp_g = 1024; exp_p = 1024; exp_o = 1024;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1", "R1", "R1");

    // R8: single update visible after the edge; R2/R3/R4 directions
    cal_en = 1'b1; upd_stb = 1'b1; err_sgn = 1'b0; x1_sgn = 1'b1; x2_sgn = 1'b0;
    step("R2", "R3", "R4");
    upd_stb = 1'b0;
    step("R8", "R8", "R8");

    // R5: strobe without enable, and enable without strobe
    cal_en = 1'b0; upd_stb = 1'b1; err_sgn = 1'b1;
    repeat (5) step("R5", "R5", "R5");
    cal_en = 1'b1; upd_stb = 1'b0;
    repeat (5) step("R5", "R5", "R5");

    // R6: drive every code to the top rail and beyond
    upd_stb = 1'b1; err_sgn = 1'b0; x1_sgn = 1'b0; x2_sgn = 1'b0;
    repeat (1100) step("R6", "R6", "R6");
    chk("R6", "gain_top", gain_code, MAXV);
    chk("R6", "ofs_top", ofs_code, MAXV);

    // R6: offset down to bottom while gain/phase stay pinned at top
    err_sgn = 1'b1; x1_sgn = 1'b1; x2_sgn = 1'b1;
    repeat (2100) step("R2", "R3", "R6");
    chk("R6", "ofs_bottom", ofs_code, 0);
    chk("R2", "gain_pinned", gain_code, MAXV);

    // R2 R3 R4 R5: random signs, strobes and enable
    for (int i = 0; i < 6000; i++) begin
      cal_en  = ($urandom() % 5) != 0;
      upd_stb = ($urandom() % 3) != 0;
      err_sgn = $urandom() % 2;
      x1_sgn  = $urandom() % 2;
      x2_sgn  = $urandom() % 2;
      step("R2", "R3", "R4");
    end

    // R1: reset mid-run returns to mid-scale
    upd_stb = 1'b0;
    rst_n = 1'b0;
    exp_g = 1024; exp_p = 1024; exp_o = 1024;
    @(negedge clk);
    check_all("R1", "R1", "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1", "R1", "R1");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule